// File: doc/BRIEF.md
# Frame Ordering Status Unit

This block holds a small bit array with one bit per frame slot. Each bit records whether the work on that frame has finished. Several requesters write to it through simple request/response ports. Producers mark slots done in whatever order their work finishes. A consumer then issues a release. In one atomic step, a release finds the run of completed slots that starts at the head pointer, clears the run, moves the head just past it and reports the freed range on a notify output. Software therefore needs no lock, no scan loop and no unlock to hand frames downstream in order.

Each port presents an operation (set or release) and a slot index. A round-robin arbiter grants one operation per cycle and gives pending sets precedence over pending releases. Every granted operation completes with a fixed latency. The response goes back to the port that issued it. A release that frees at least one slot also drives a single-cycle notify pulse that carries the range.

Top module: `fos_unit`

## Requirements
- R1: After reset every slot is clear and the head is 0. No response and no notify is driven until a request is granted.
- R2: A set of a clear slot marks it complete and returns a response with the error flag low.
- R3: A set of a slot that is already complete returns a response with the error flag high and leaves the array unchanged.
- R4: A release returns the old head in rsp_data_o[5:0] and the run length in rsp_data_o[14:8], with all other data bits zero. The run length is the number of consecutive complete slots starting at the head. The release clears those slots and advances the head by the run length modulo 64.
- R5: A release when the head slot is clear returns a run length of 0, leaves the head unchanged and produces no notify.
- R6: notify_valid_o is high for exactly the cycle in which a release response with a non-zero count is returned. It carries the old head and the count.
- R7: The response to any operation appears exactly two cycles after the cycle in which req_ready_o granted it, on that port's rsp_valid_o bit.
- R8: A run that crosses slot 63 continues at slot 0 and is released as one range.
- R9: When all 64 slots are complete, a release reports a count of 64 and the head stays where it was.
- R10: When sets and releases are pending in the same cycle, a set is granted first. Among requests of the same kind, the grant rotates to the port after the one last granted. Ops are encoded 0 = set, 1 = release.
- R11: At most one request is granted per cycle, and only a port whose request is valid is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | NUM_REQ | Request present, one bit per port |
| req_op_i | input | NUM_REQ | Operation per port: 0 set, 1 release |
| req_idx_i | input | NUM_REQ*IDX_W | Slot index per port (used by set) |
| req_ready_o | output | NUM_REQ | Grant, one-hot or zero |
| rsp_valid_o | output | NUM_REQ | Response strobe for the issuing port |
| rsp_err_o | output | NUM_REQ | Duplicate-set error for the issuing port |
| rsp_data_o | output | DATA_W | Release result: start [5:0], count [14:8] |
| notify_valid_o | output | 1 | Released range pulse |
| notify_start_o | output | IDX_W | First released slot |
| notify_count_o | output | CNT_W | Number of released slots |

## Verification
The bench aims at runs that stop early or cross the wrap point. A scan that ignored wrap would report a short count at slot 63, and a head update that used only the low bits wrongly would drift when the array is full. A duplicate set has to be caught without disturbing the array, so a later release must still report the same run. Simultaneous set and release requests check ordering: a design that served the release first would report a run one slot shorter than expected. Every response is also checked against its expected cycle, so a stray pipeline stage shows up as a mismatch.

// File: rtl/fos_pkg.sv
package fos_pkg;
  typedef enum logic {
    OP_SET = 1'b0,
    OP_REL = 1'b1
  } op_e;

  localparam int unsigned CNT_LSB = 8;
endpackage

// File: rtl/fos_arbiter.sv
module fos_arbiter #(
  parameter int unsigned NUM_REQ = 2,
  localparam int unsigned PW = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_REQ-1:0] valid_i,
  input  logic [NUM_REQ-1:0] is_set_i,
  output logic [NUM_REQ-1:0] gnt_o,
  output logic [PW-1:0]      gnt_idx_o
);
  logic [PW-1:0] ptr_q;
  logic          found;

  // pass 0 considers sets only, pass 1 any request
  always_comb begin
    gnt_o     = '0;
    gnt_idx_o = '0;
    found     = 1'b0;
    for (int pass = 0; pass < 2; pass++) begin
      for (int k = 0; k < NUM_REQ; k++) begin
        int j;
        j = (int'(ptr_q) + k) % NUM_REQ;
        if (!found && valid_i[j] && (pass == 1 || is_set_i[j])) begin
          found     = 1'b1;
          gnt_o[j]  = 1'b1;
          gnt_idx_o = PW'(j);
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= '0;
    else if (found) ptr_q <= (int'(gnt_idx_o) == NUM_REQ - 1) ? '0 : gnt_idx_o + PW'(1);
  end
endmodule

// File: rtl/fos_run_scan.sv
module fos_run_scan #(
  parameter int unsigned SLOTS = 64,
  localparam int unsigned IDX_W = $clog2(SLOTS),
  localparam int unsigned CNT_W = $clog2(SLOTS + 1)
) (
  input  logic [SLOTS-1:0] status_i,
  input  logic [IDX_W-1:0] head_i,
  output logic [CNT_W-1:0] run_o,
  output logic [SLOTS-1:0] clr_mask_o
);
  logic [2*SLOTS-1:0] rot_dbl, msk_dbl;
  logic [SLOTS-1:0]   rot, lin_mask;
  logic               stop;

  always_comb begin
    rot_dbl = {status_i, status_i} >> head_i;
    rot     = rot_dbl[SLOTS-1:0];
    run_o   = '0;
    stop    = 1'b0;
    for (int i = 0; i < SLOTS; i++) begin
      if (!stop) begin
        if (rot[i]) run_o = run_o + CNT_W'(1);
        else        stop  = 1'b1;
      end
    end
    for (int i = 0; i < SLOTS; i++) lin_mask[i] = (i < int'(run_o));
    msk_dbl    = {lin_mask, lin_mask} << head_i;
    clr_mask_o = msk_dbl[2*SLOTS-1:SLOTS];
  end
endmodule

// File: rtl/fos_unit.sv
module fos_unit #(
  parameter int unsigned NUM_REQ = 2,
  parameter int unsigned SLOTS   = 64,
  parameter int unsigned DATA_W  = 32,
  localparam int unsigned IDX_W  = $clog2(SLOTS),
  localparam int unsigned CNT_W  = $clog2(SLOTS + 1),
  localparam int unsigned PW     = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NUM_REQ-1:0]       req_valid_i,
  input  logic [NUM_REQ-1:0]       req_op_i,
  input  logic [NUM_REQ*IDX_W-1:0] req_idx_i,
  output logic [NUM_REQ-1:0]       req_ready_o,
  output logic [NUM_REQ-1:0]       rsp_valid_o,
  output logic [NUM_REQ-1:0]       rsp_err_o,
  output logic [DATA_W-1:0]        rsp_data_o,
  output logic                     notify_valid_o,
  output logic [IDX_W-1:0]         notify_start_o,
  output logic [CNT_W-1:0]         notify_count_o
);
  import fos_pkg::*;

  logic [NUM_REQ-1:0] gnt;
  logic [PW-1:0]      gnt_idx;
  logic [SLOTS-1:0]   status_q, status_d, clr_mask;
  logic [IDX_W-1:0]   head_q, head_d, sel_idx;
  logic [CNT_W-1:0]   run;
  logic               any_gnt, sel_rel, dup;

  fos_arbiter #(.NUM_REQ(NUM_REQ)) u_arb (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (req_valid_i),
    .is_set_i (~req_op_i),
    .gnt_o    (gnt),
    .gnt_idx_o(gnt_idx)
  );

  fos_run_scan #(.SLOTS(SLOTS)) u_scan (
    .status_i  (status_q),
    .head_i    (head_q),
    .run_o     (run),
    .clr_mask_o(clr_mask)
  );

  assign req_ready_o = gnt;
  assign any_gnt     = |gnt;
  assign sel_idx     = req_idx_i[gnt_idx*IDX_W +: IDX_W];
  assign sel_rel     = (op_e'(req_op_i[gnt_idx]) == OP_REL);
  assign dup         = status_q[sel_idx];

  always_comb begin
    status_d = status_q;
    head_d   = head_q;
    if (any_gnt) begin
      if (sel_rel) begin
        status_d = status_q & ~clr_mask;
        head_d   = head_q + run[IDX_W-1:0];
      end else if (!dup) begin
        status_d[sel_idx] = 1'b1;
      end
    end
  end

  // stage 1: operation result, array already updated
  logic             s1_vld, s1_err, s1_rel;
  logic [PW-1:0]    s1_port;
  logic [IDX_W-1:0] s1_start;
  logic [CNT_W-1:0] s1_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= '0;
      head_q   <= '0;
      s1_vld   <= 1'b0;
      s1_err   <= 1'b0;
      s1_rel   <= 1'b0;
      s1_port  <= '0;
      s1_start <= '0;
      s1_cnt   <= '0;
    end else begin
      status_q <= status_d;
      head_q   <= head_d;
      s1_vld   <= any_gnt;
      s1_err   <= any_gnt && !sel_rel && dup;
      s1_rel   <= any_gnt && sel_rel;
      s1_port  <= gnt_idx;
      s1_start <= head_q;
      s1_cnt   <= (any_gnt && sel_rel) ? run : '0;
    end
  end

  // stage 2: response and notify registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o    <= '0;
      rsp_err_o      <= '0;
      rsp_data_o     <= '0;
      notify_valid_o <= 1'b0;
      notify_start_o <= '0;
      notify_count_o <= '0;
    end else begin
      rsp_valid_o <= '0;
      rsp_err_o   <= '0;
      rsp_data_o  <= '0;
      if (s1_vld) begin
        rsp_valid_o[s1_port] <= 1'b1;
        rsp_err_o[s1_port]   <= s1_err;
        if (s1_rel) begin
          rsp_data_o[IDX_W-1:0]            <= s1_start;
          rsp_data_o[CNT_LSB +: CNT_W]     <= s1_cnt;
        end
      end
      notify_valid_o <= s1_rel && (s1_cnt != '0);
      notify_start_o <= s1_start;
      notify_count_o <= s1_cnt;
    end
  end
endmodule

// File: rtl/fos_unit_chk.sv
module fos_unit_chk #(
  parameter int unsigned NUM_REQ = 2,
  parameter int unsigned SLOTS   = 64,
  parameter int unsigned DATA_W  = 32,
  localparam int unsigned IDX_W  = $clog2(SLOTS),
  localparam int unsigned CNT_W  = $clog2(SLOTS + 1)
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic [NUM_REQ-1:0]       req_valid_i,
  input logic [NUM_REQ-1:0]       req_op_i,
  input logic [NUM_REQ-1:0]       req_ready_o,
  input logic [NUM_REQ-1:0]       rsp_valid_o,
  input logic [NUM_REQ-1:0]       rsp_err_o,
  input logic                     notify_valid_o,
  input logic [CNT_W-1:0]         notify_count_o
);
  // R11
  one_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(req_ready_o) && ((req_ready_o & ~req_valid_i) == '0));

  // R10
  set_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(req_valid_i & ~req_op_i)) |-> (|(req_ready_o & ~req_op_i)));

  // R7
  fixed_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(req_valid_i & req_ready_o)) |=> ##1 (|rsp_valid_o));

  // R7
  one_rsp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(rsp_valid_o) && ((rsp_err_o & ~rsp_valid_o) == '0));

  // R6
  notify_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    notify_valid_o |-> (notify_count_o != '0) && (|rsp_valid_o) && !(|rsp_err_o));

  // R9
  count_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    notify_valid_o |-> (int'(notify_count_o) <= SLOTS));
endmodule

bind fos_unit fos_unit_chk #(.NUM_REQ(NUM_REQ), .SLOTS(SLOTS), .DATA_W(DATA_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .req_valid_i   (req_valid_i),
  .req_op_i      (req_op_i),
  .req_ready_o   (req_ready_o),
  .rsp_valid_o   (rsp_valid_o),
  .rsp_err_o     (rsp_err_o),
  .notify_valid_o(notify_valid_o),
  .notify_count_o(notify_count_o)
);

// File: tb/fos_unit_test.sv
module fos_unit_test;
  localparam int N = 2;
  localparam int SL = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  req_valid = '0, req_op = '0, req_ready, rsp_valid, rsp_err;
  logic [11:0] req_idx = '0;
  logic [31:0] rsp_data;
  logic        ntf_valid;
  logic [5:0]  ntf_start;
  logic [6:0]  ntf_count;

  always #10 clk = ~clk;

  fos_unit uut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_op_i(req_op), .req_idx_i(req_idx),
    .req_ready_o(req_ready), .rsp_valid_o(rsp_valid), .rsp_err_o(rsp_err),
    .rsp_data_o(rsp_data), .notify_valid_o(ntf_valid),
    .notify_start_o(ntf_start), .notify_count_o(ntf_count)
  );

  typedef struct {
    int      port;
    bit      err;
    bit      rel;
    int      start;
    int      cnt;
    longint  cyc;
    string   tag;
  } exp_t;

  exp_t    sb[$];
  int      total = 0, fails = 0;
  longint  cyc = 0;
  bit      m_bits [SL];
  int      m_head = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // model-side expectations
  function automatic exp_t model_set(int port, int idx, longint c, string tag);
    exp_t e;
    e.port = port; e.rel = 0; e.start = 0; e.cnt = 0; e.cyc = c; e.tag = tag;
    e.err = m_bits[idx];
    if (!e.err) m_bits[idx] = 1;
    return e;
  endfunction

  function automatic exp_t model_rel(int port, longint c, string tag);
    exp_t e;
    int n = 0;
    while (n < SL && m_bits[(m_head + n) % SL]) n++;
    for (int i = 0; i < n; i++) m_bits[(m_head + i) % SL] = 0;
    e.port = port; e.err = 0; e.rel = 1; e.start = m_head; e.cnt = n; e.cyc = c; e.tag = tag;
    m_head = (m_head + n) % SL;
    return e;
  endfunction

  task automatic issue(input int port, input bit op, input int idx, input string tag);
    @(negedge clk);
    req_valid[port] = 1'b1;
    req_op[port] = op;
    req_idx[port*6 +: 6] = 6'(idx);
    if (op) sb.push_back(model_rel(port, cyc + 2, tag));
    else    sb.push_back(model_set(port, idx, cyc + 2, tag));
    #1;
    check(req_ready == 2'(1 << port), "R11 grant", req_ready, 1 << port);
    @(negedge clk);
    req_valid[port] = 1'b0;
  endtask

  // monitor: compare each response with the head of the scoreboard
  always @(negedge clk) begin
    if (rst_n && (|rsp_valid || ntf_valid)) begin
      if (sb.size() == 0) begin
        check(0, "R7 unexpected response", rsp_valid, 0);
      end else begin
        exp_t e;
        bit   en;
        e = sb.pop_front();
        en = e.rel && e.cnt > 0;
        check(rsp_valid == 2'(1 << e.port), {e.tag, " rsp port"}, rsp_valid, 1 << e.port);
        check(cyc == e.cyc, "R7 latency", cyc, e.cyc);
        check(rsp_err[e.port] == e.err, {e.tag, " err"}, rsp_err[e.port], e.err);
        check(int'(rsp_data[5:0]) == e.start && int'(rsp_data[14:8]) == e.cnt &&
              rsp_data[31:15] == '0 && rsp_data[7:6] == '0,
              {e.tag, " data"}, rsp_data, (e.cnt << 8) | e.start);
        check(ntf_valid == en, "R6 notify valid", ntf_valid, en);
        if (en)
          check(int'(ntf_start) == e.start && int'(ntf_count) == e.cnt,
                "R6 notify range", {ntf_start, ntf_count}, (e.start << 7) | e.cnt);
      end
    end
  end

  task automatic run_tests();
    exp_t e;
    repeat (3) @(negedge clk);
    check(req_ready == 0 && rsp_valid == 0 && ntf_valid == 0, "R1 reset outputs",
          {req_ready, rsp_valid, ntf_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(rsp_valid == 0 && ntf_valid == 0, "R1 idle after reset", {rsp_valid, ntf_valid}, 0);
    issue(0, 1, 0, "R1 R5 empty release");
    issue(1, 0, 2, "R2 set");
    issue(0, 0, 0, "R2 set");
    issue(1, 1, 0, "R4 release run");
    issue(0, 1, 0, "R5 head clear");
    issue(0, 0, 1, "R2 set");
    issue(1, 1, 0, "R4 out of order run");
    issue(0, 0, 5, "R2 set");
    issue(1, 0, 5, "R3 duplicate");
    issue(0, 0, 3, "R2 set");
    issue(1, 0, 4, "R2 set");
    issue(0, 1, 0, "R3 R4 run after dup");
    // walk head up to 62
    for (int i = m_head; i < 62; i++) if (!m_bits[i]) issue(i % 2, 0, i, "R2 fill");
    issue(0, 1, 0, "R4 advance");
    check(m_head == 62, "R8 model head", m_head, 62);
    issue(0, 0, 62, "R2 set");
    issue(1, 0, 63, "R2 set");
    issue(0, 0, 0, "R2 set");
    issue(1, 0, 1, "R2 set");
    issue(1, 1, 0, "R8 wrap release");
    // fill every slot
    for (int i = 0; i < SL; i++) if (!m_bits[i]) issue(i % 2, 0, i, "R2 fill all");
    issue(0, 1, 0, "R9 full release");
    check(m_head == 2, "R9 model head", m_head, 2);
    issue(1, 1, 0, "R5 empty again");
    // simultaneous set and release, port 1 granted last so ptr points at port 0
    @(negedge clk);
    req_valid = 2'b11; req_op = 2'b01; req_idx[6 +: 6] = 6'(m_head);
    sb.push_back(model_set(1, m_head, cyc + 2, "R10 set first"));
    #1;
    check(req_ready == 2'b10, "R10 set before release", req_ready, 2);
    @(negedge clk);
    req_valid[1] = 1'b0;
    sb.push_back(model_rel(0, cyc + 2, "R10 release second"));
    #1;
    check(req_ready == 2'b01, "R10 release granted", req_ready, 1);
    @(negedge clk);
    req_valid = 2'b00;
    // round robin: port 0 granted last, port 1 wins
    @(negedge clk);
    req_valid = 2'b11; req_op = 2'b00;
    req_idx[0 +: 6] = 6'(m_head + 1); req_idx[6 +: 6] = 6'(m_head + 2);
    sb.push_back(model_set(1, (m_head + 2) % SL, cyc + 2, "R10 rr first"));
    #1;
    check(req_ready == 2'b10, "R10 round robin", req_ready, 2);
    @(negedge clk);
    req_valid[1] = 1'b0;
    sb.push_back(model_set(0, (m_head + 1) % SL, cyc + 2, "R10 rr second"));
    #1;
    check(req_ready == 2'b01, "R10 round robin next", req_ready, 1);
    @(negedge clk);
    req_valid = 2'b00;
    issue(0, 0, m_head, "R2 set");
    issue(1, 1, 0, "R4 release three");
    repeat (4) @(negedge clk);
    check(sb.size() == 0, "R7 all responses seen", sb.size(), 0);
  endtask

  initial begin
    fork
      run_tests();
      begin
        repeat (20000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog expired actual=1 expected=0");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule